// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block moves incoming frames into memory buffers described by a ring of receive descriptors, then hands each filled buffer back to software. It polls the descriptor at the current ring index until software marks it as owned by hardware, reads that descriptor's buffer size, end-of-ring flag and buffer address, and then accepts one frame from an upstream receiver. The receiver presents the frame one byte per cycle, with a last-byte flag and an error flag. Bytes are packed little-endian into 32-bit writes on a single memory port with byte enables. When the frame ends, the engine writes status into control word 0. The status holds the stored length and the error flags, and the owner bit is cleared. The engine then raises a one-cycle completion pulse and moves to the next descriptor.

Buffers are expected to start two bytes past a word boundary. The first write of a frame therefore fills only the upper halfword. A frame that starts while no hardware-owned descriptor is ready is discarded and counted. Frames longer than the buffer are truncated and flagged.

Descriptor layout, 16 bytes per entry starting at `ring_base_i`:

| Offset | Content |
|---|---|
| +0 | Control word 0: bit 31 owner (1 = hardware), bits [10:0] length on write-back, bit 16 receive error, bit 17 overflow, bit 18 bad buffer address |
| +4 | Control word 1: bits [10:0] buffer size in bytes (normally 1536), bit 31 end of ring |
| +8 | Buffer byte address |

Top module: `rxd_wb_engine`

## Requirements
- R1: After reset `rx_done_o` is 0, `missed_cnt_o` is 0, and no memory write is issued while no frame arrives.
- R2: A frame is written only into a descriptor whose control word 0 bit 31 reads 1, and the completion write to control word 0 leaves bit 31 at 0.
- R3: The completion status carries the number of stored bytes in bits [10:0] and sets bit 16 when the error input was high on any byte of the frame.
- R4: A frame longer than the size in control word 1 bits [10:0] is stored only up to that size, no byte lands past the buffer end, the length reports the size, and bit 17 is set.
- R5: Descriptor i sits at `ring_base_i + 16*i`; after each completion the index advances by one, or returns to 0 when control word 1 bit 31 of the finished descriptor is set.
- R6: A buffer address whose bits [1:0] are not 2'b10 receives no data write; the frame is still completed with its length and with bit 18 set.
- R7: Byte k of a frame is stored at buffer address + k; the first write covers only byte lanes 2 and 3, and bytes outside the stored range are left untouched.
- R8: While the current descriptor is owned by software it is re-read after `POLL_CYCLES` idle cycles, so a descriptor armed later is picked up without any other stimulus.
- R9: A frame whose first byte arrives while no descriptor is ready is discarded whole: no memory write, no completion, and `missed_cnt_o` increments by one.
- R10: `rx_done_o` is a single-cycle pulse, raised once per status write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receive enable; when low no descriptor is fetched and no frame is accepted |
| ring_base_i | input | 32 | Byte address of descriptor 0 |
| rx_valid_i | input | 1 | Byte valid from upstream receiver |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Marks the final byte of a frame |
| rx_err_i | input | 1 | Upstream error for the current byte |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the read request |
| rx_done_o | output | 1 | Completion pulse, one per status write-back |
| missed_cnt_o | output | 16 | Count of frames discarded for lack of a descriptor |

## Verification
The engine is driven with a set of frames that differ in length, error marking and buffer size: a 64-byte clean frame, a short frame with error, a single-byte frame that is both first and last, and frames longer than a small buffer, with and without error. Together they separate correct length reporting from truncation, the error flag from the overflow flag, and a completion on the first byte from one after many. Byte contents and guard bytes around each buffer show the halfword start lane and any write past the end. Directed cases cover a frame arriving against a software-owned descriptor, which tests discard, counting and later re-polling. They also cover a word-aligned buffer address and the ring wrap with a trap descriptor placed past the end-of-ring entry.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 31;
  localparam int ERR_BIT = 16;
  localparam int OVF_BIT = 17;
  localparam int ALN_BIT = 18;
  localparam logic [1:0] BUF_PHASE = 2'b10;

  typedef enum logic [2:0] {
    S_POLL, S_OWN, S_SIZE, S_ADDR, S_READY, S_RECV, S_STAT, S_WAIT
  } rxd_state_e;
endpackage

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
  parameter int CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q >= LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r8_wait_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= LAST);
endmodule

// File: rtl/rxd_frame_track.sv
module rxd_frame_track #(
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic              accept_i,
  output logic              sof_o,
  output logic [MISS_W-1:0] missed_o
);
  logic in_frame_q;
  logic [MISS_W-1:0] missed_q;

  assign sof_o    = valid_i && !in_frame_q;
  assign missed_o = missed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      missed_q   <= '0;
    end else begin
      if (valid_i) in_frame_q <= !last_i;
      if (sof_o && !accept_i) missed_q <= missed_q + 1'b1;
    end
  end

  // R9: at most one miss per cycle, only at a frame start
  a_r9_missed_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (missed_q != $past(missed_q)) |-> $past(sof_o));
endmodule

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] base_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        flush_i,
  output logic        wr_o,
  output logic [31:0] waddr_o,
  output logic [3:0]  wbe_o,
  output logic [31:0] wdata_o
);
  logic [1:0]  lane_q;
  logic [31:0] waddr_q;
  logic [31:0] dacc_q;
  logic [3:0]  be_q;
  logic        first_q;
  logic [31:0] wdata_c;
  logic [3:0]  be_c;

  always_comb begin
    wdata_c = dacc_q;
    wdata_c[lane_q*8 +: 8] = byte_i;
    be_c = be_q | (4'b0001 << lane_q);
  end

  assign wr_o    = byte_vld_i && ((lane_q == 2'd3) || flush_i);
  assign waddr_o = waddr_q;
  assign wbe_o   = be_c;
  assign wdata_o = wdata_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q  <= '0;
      waddr_q <= '0;
      dacc_q  <= '0;
      be_q    <= '0;
      first_q <= 1'b0;
    end else if (start_i) begin
      lane_q  <= base_i[1:0];
      waddr_q <= {base_i[31:2], 2'b00};
      dacc_q  <= '0;
      be_q    <= '0;
      first_q <= 1'b1;
    end else if (byte_vld_i) begin
      lane_q <= lane_q + 1'b1;
      if (wr_o) begin
        dacc_q  <= '0;
        be_q    <= '0;
        first_q <= 1'b0;
        if (lane_q == 2'd3) waddr_q <= waddr_q + 32'd4;
      end else begin
        dacc_q <= wdata_c;
        be_q   <= be_c;
      end
    end
  end

  // R7: a full first write of a halfword-offset buffer covers only lanes 2 and 3
  a_r7_first_halfword: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && first_q && !flush_i) |-> (wbe_o == 4'b1100));
  a_r7_word_aligned_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (waddr_o[1:0] == 2'b00));
endmodule

// File: rtl/rxd_wb_engine.sv
module rxd_wb_engine
  import rxd_pkg::*;
#(
  parameter int LEN_W       = 11,
  parameter int IDX_W       = 6,
  parameter int POLL_CYCLES = 1,
  parameter int MISS_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [31:0]       ring_base_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              rx_done_o,
  output logic [MISS_W-1:0] missed_cnt_o
);
  localparam int DESC_SHIFT = 4;
  localparam logic [31:0] OFS_CTL1 = 32'd4;
  localparam logic [31:0] OFS_BUF  = 32'd8;

  rxd_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] size_q, cnt_q;
  logic             eor_q, err_q, ovf_q;
  logic [31:0]      buf_q;
  logic [31:0]      desc_addr;
  logic [31:0]      stat_w;
  logic             addr_ok, sof, accept, receiving, byte_act, take, flush;
  logic             owned, tmr_done;
  logic             pk_wr;
  logic [31:0]      pk_addr, pk_wdata;
  logic [3:0]       pk_be;

  assign desc_addr = ring_base_i + (32'(idx_q) << DESC_SHIFT);
  assign owned     = mem_rdata_i[OWN_BIT];
  assign addr_ok   = (buf_q[1:0] == BUF_PHASE);
  assign accept    = sof && en_i && (state_q == S_READY);
  assign receiving = accept || (state_q == S_RECV);
  assign byte_act  = rx_valid_i && receiving;
  assign take      = byte_act && (cnt_q < size_q);
  assign flush     = rx_last_i || ((cnt_q + LEN_W'(1)) == size_q);

  rxd_frame_track #(.MISS_W(MISS_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rx_valid_i),
    .last_i  (rx_last_i),
    .accept_i(accept),
    .sof_o   (sof),
    .missed_o(missed_cnt_o)
  );

  rxd_poll_timer #(.CYCLES(POLL_CYCLES)) u_poll (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(state_q == S_OWN && !owned),
    .run_i (state_q == S_WAIT),
    .done_o(tmr_done)
  );

  rxd_byte_packer u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (state_q == S_ADDR),
    .base_i    (mem_rdata_i),
    .byte_vld_i(take && addr_ok),
    .byte_i    (rx_data_i),
    .flush_i   (flush),
    .wr_o      (pk_wr),
    .waddr_o   (pk_addr),
    .wbe_o     (pk_be),
    .wdata_o   (pk_wdata)
  );

  always_comb begin
    stat_w = '0;
    stat_w[LEN_W-1:0] = cnt_q;
    stat_w[ERR_BIT]   = err_q;
    stat_w[OVF_BIT]   = ovf_q;
    stat_w[ALN_BIT]   = !addr_ok;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_POLL:  if (en_i) state_d = S_OWN;
      S_OWN:   state_d = owned ? S_SIZE : S_WAIT;
      S_SIZE:  state_d = S_ADDR;
      S_ADDR:  state_d = S_READY;
      S_READY: if (accept) state_d = rx_last_i ? S_STAT : S_RECV;
      S_RECV:  if (byte_act && rx_last_i) state_d = S_STAT;
      S_STAT:  state_d = S_POLL;
      S_WAIT:  if (tmr_done) state_d = S_POLL;
      default: state_d = S_POLL;
    endcase
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr;
    mem_be_o    = 4'hF;
    mem_wdata_o = '0;
    case (state_q)
      S_POLL: mem_req_o = en_i;
      S_OWN: if (owned) begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr + OFS_CTL1;
      end
      S_SIZE: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr + OFS_BUF;
      end
      S_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = stat_w;
      end
      default: if (receiving && pk_wr) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = pk_addr;
        mem_be_o    = pk_be;
        mem_wdata_o = pk_wdata;
      end
    endcase
  end

  assign rx_done_o = (state_q == S_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_POLL;
      idx_q   <= '0;
      size_q  <= '0;
      eor_q   <= 1'b0;
      buf_q   <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_SIZE) begin
        size_q <= mem_rdata_i[LEN_W-1:0];
        eor_q  <= mem_rdata_i[EOR_BIT];
      end
      if (state_q == S_ADDR) begin
        buf_q <= mem_rdata_i;
        cnt_q <= '0;
        err_q <= 1'b0;
        ovf_q <= 1'b0;
      end
      if (take) cnt_q <= cnt_q + 1'b1;
      if (byte_act && rx_err_i) err_q <= 1'b1;
      if (byte_act && !take) ovf_q <= 1'b1;
      if (state_q == S_STAT) idx_q <= eor_q ? '0 : idx_q + 1'b1;
    end
  end

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);
  a_r2_owner_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> (mem_req_o && mem_we_o && !mem_wdata_o[OWN_BIT]));
  a_r4_len_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> (mem_wdata_o[LEN_W-1:0] <= size_q));
  a_r6_no_write_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !rx_done_o) |-> addr_ok);
  a_r9_no_write_outside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !rx_done_o) |-> byte_act);
endmodule

// File: tb/tb_rxd_wb_engine.sv
`timescale 1ns/1ps
module tb_rxd_wb_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        rx_done;
  logic [15:0] missed;

  int checks = 0, errors = 0;
  int done_cnt = 0, wr_cnt = 0, cyc = 0;

  logic [31:0] mem_w [0:4095];

  always #2.5 clk = ~clk;

  rxd_wb_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ring_base_i(32'h0),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_err_i(rx_err),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rx_done_o(rx_done), .missed_cnt_o(missed)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_done) done_cnt <= done_cnt + 1;
    if (mem_req && mem_we) begin
      wr_cnt <= wr_cnt + 1;
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem_w[mem_addr[13:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end else if (mem_req) begin
      mem_rdata <= mem_w[mem_addr[13:2]];
    end
  end

  typedef struct packed {
    logic [15:0] len;
    logic        err;
    logic [15:0] size;
    logic [15:0] exp_len;
    logic [2:0]  flags;
  } vec_t;

  // flags: bit0 = receive error (bit 16), bit1 = overflow (bit 17), bit2 = bad address (bit 18)
  localparam vec_t VEC [5] = '{
    '{16'd64, 1'b0, 16'd1536, 16'd64, 3'b000},
    '{16'd61, 1'b1, 16'd1536, 16'd61, 3'b001},
    '{16'd1,  1'b0, 16'd1536, 16'd1,  3'b000},
    '{16'd20, 1'b0, 16'd16,   16'd16, 3'b010},
    '{16'd18, 1'b1, 16'd16,   16'd16, 3'b011}
  };

  function automatic logic [7:0] pat(int v, int k);
    return 8'(v * 37 + k * 13 + 5);
  endfunction

  function automatic logic [7:0] rbyte(int a);
    return mem_w[a >> 2][(a % 4) * 8 +: 8];
  endfunction

  task automatic wbyte(int a, logic [7:0] d);
    mem_w[a >> 2][(a % 4) * 8 +: 8] = d;
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int buf_of(int idx);
    return 32'h102 + idx * 32'h600;
  endfunction

  task automatic arm(int idx, int size, bit eor, int bufa);
    mem_w[idx*4 + 0] = 32'h8000_0000;
    mem_w[idx*4 + 1] = {eor, 15'd0, 16'(size)};
    mem_w[idx*4 + 2] = bufa;
  endtask

  task automatic guard(int bufa, int n);
    for (int a = bufa - 2; a < bufa + n + 4; a++) wbyte(a, 8'hA5);
  endtask

  task automatic send(int v, int len, bit err);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = pat(v, k);
      rx_last  = (k == len - 1);
      rx_err   = err && (k == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx, bad, d0, w0;
    logic [31:0] st, exp_st, keep;
    for (int i = 0; i < 4096; i++) mem_w[i] = '0;
    mem_rdata = '0;
    mem_w[12] = 32'h8000_0000;
    mem_w[13] = 32'd1536;
    mem_w[14] = 32'h1302;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    repeat (20) @(negedge clk);
    chk(rx_done == 1'b0, "R1 done idle", 32'(rx_done), 0);
    chk(missed == 16'd0, "R1 missed zero", 32'(missed), 0);
    chk(wr_cnt == 0, "R1 no writes", wr_cnt, 0);

    idx = 0;
    for (int v = 0; v < 5; v++) begin
      arm(idx, VEC[v].size, idx == 2, buf_of(idx));
      guard(buf_of(idx), VEC[v].exp_len);
      repeat (20) @(negedge clk);
      d0 = done_cnt;
      send(v, VEC[v].len, VEC[v].err);
      repeat (10) @(negedge clk);
      chk(done_cnt == d0 + 1, "R10 one pulse", done_cnt - d0, 1);
      st = mem_w[idx*4];
      exp_st = (32'(VEC[v].flags) << 16) | 32'(VEC[v].exp_len);
      chk(st == exp_st, "R3 R4 R2 status", st, exp_st);
      bad = 0;
      for (int k = 0; k < VEC[v].exp_len; k++)
        if (rbyte(buf_of(idx) + k) != pat(v, k)) bad++;
      chk(bad == 0, "R7 data bytes", bad, 0);
      chk(rbyte(buf_of(idx) - 1) == 8'hA5 && rbyte(buf_of(idx) - 2) == 8'hA5,
          "R7 lanes below buffer", rbyte(buf_of(idx) - 1), 8'hA5);
      chk(rbyte(buf_of(idx) + VEC[v].exp_len) == 8'hA5, "R4 past end untouched",
          rbyte(buf_of(idx) + VEC[v].exp_len), 8'hA5);
      idx = (idx == 2) ? 0 : idx + 1;
    end
    chk(mem_w[12] == 32'h8000_0000, "R5 wrap skips trap", mem_w[12], 32'h8000_0000);

    // idx is 2, software-owned: frame must be discarded
    keep = mem_w[8];
    d0 = done_cnt; w0 = wr_cnt;
    send(9, 10, 1'b0);
    repeat (15) @(negedge clk);
    chk(missed == 16'd1, "R9 missed count", 32'(missed), 1);
    chk(done_cnt == d0, "R9 no completion", done_cnt - d0, 0);
    chk(wr_cnt == w0, "R9 no write", wr_cnt - w0, 0);
    chk(mem_w[8] == keep, "R2 sw-owned untouched", mem_w[8], keep);

    // arming later is picked up by polling; word-aligned buffer is rejected
    arm(2, 1536, 1'b1, 32'hD04);
    guard(32'hD04, 12);
    repeat (20) @(negedge clk);
    d0 = done_cnt;
    send(10, 9, 1'b0);
    repeat (10) @(negedge clk);
    chk(done_cnt == d0 + 1, "R8 repoll picks up", done_cnt - d0, 1);
    chk(mem_w[8] == 32'h0004_0009, "R6 align status", mem_w[8], 32'h0004_0009);
    bad = 0;
    for (int a = 32'hD02; a < 32'hD10; a++) if (rbyte(a) != 8'hA5) bad++;
    chk(bad == 0, "R6 buffer untouched", bad, 0);

    // wrap: next descriptor is 0, not 3
    arm(0, 1536, 1'b0, buf_of(0));
    guard(buf_of(0), 4);
    repeat (20) @(negedge clk);
    send(11, 4, 1'b0);
    repeat (10) @(negedge clk);
    chk(mem_w[0] == 32'd4, "R5 wrap to base", mem_w[0], 4);
    chk(mem_w[12] == 32'h8000_0000, "R5 trap untouched", mem_w[12], 32'h8000_0000);
    chk(rbyte(buf_of(0) + 3) == pat(11, 3) && rbyte(buf_of(0) + 4) == 8'hA5,
        "R7 final partial word", rbyte(buf_of(0) + 3), pat(11, 3));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule